// File: doc/BRIEF.md
# Two-Line Level Interrupt Router

This block gathers a word of level-sensitive interrupt requests and drives two interrupt lines toward a processor. Each request passes through a synchronizer. It is then qualified by a per-source enable mask and sent to one of the two lines by a per-source routing bit. The top bit of the mask is a master switch that gates both lines.

Software reaches the block through a single-cycle register port: an address, a write strobe, write data and combinational read data. The enable mask has no register that software can write directly. It is changed only by writing ones to a set window or to a clear window. Software can read the synchronized request levels, the routing word, and a qualified status word for each line. There is no acknowledge. A line stays active for as long as its qualifying request stays high.

Top module: `irq_router`

## Requirements
- R1: After reset the enable mask, the routing word and both interrupt lines are zero.
- R2: A write to offset 0x34 sets each mask bit whose write-data bit is 1 and keeps every other mask bit. Reads of 0x34 return the mask.
- R3: A write to offset 0x38 clears each mask bit whose write-data bit is 1 and keeps every other mask bit. Writing all ones clears the whole mask. Reads of 0x38 return the mask.
- R4: Mask bit 31 is the master enable. While it is 0, neither interrupt line is asserted.
- R5: Offset 0x20 holds the routing word and reads back what was written. Routing bit 0 sends a source to line 0 (irq_o[0]). Routing bit 1 sends it to line 1 (irq_o[1]).
- R6: Offset 0x30 reads the request levels two clock edges after they change at src_i, whatever the mask and routing hold.
- R7: Offset 0x00 (line 0) and offset 0x04 (line 1) read raw AND mask AND the routing match for that line. Bit 31 of both reads as 0.
- R8: Each line is the OR of its status bits ANDed with the master enable, taken through a register. A change in mask or routing reaches irq_o one edge after the write is taken.
- R9: Requests are levels. A line stays asserted for as long as its source stays high and enabled, and it drops three edges after the source falls.
- R10: Writes to 0x00, 0x04 and 0x30 change no state. Reads of any offset that is not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt requests, asynchronous |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 2 | Interrupt lines: bit 0 is line 0, bit 1 is line 1 |

## Verification
Two events can land on the same edge: a clear-window write that disables a source, and that source's synchronized level rising. The bench provokes this by raising the request exactly two edges before the clear write is taken, so both reach the state registers on the same edge. Both lines must then stay low on every sampled cycle that follows, and the raw read must still show the request. A second collision drops the master enable while several routed sources are active, and checks that the lines fall one edge later.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned OFS_LINE0 = 'h00;
    localparam int unsigned OFS_LINE1 = 'h04;
    localparam int unsigned OFS_ROUTE = 'h20;
    localparam int unsigned OFS_RAW   = 'h30;
    localparam int unsigned OFS_SET   = 'h34;
    localparam int unsigned OFS_CLR   = 'h38;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LINE0,
        SEL_LINE1,
        SEL_ROUTE,
        SEL_RAW,
        SEL_SET,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  reg_sel_e     sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] route_o
);

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] route;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (sel_i)
                SEL_SET:   r_d.mask  = r_q.mask | wdata_i;
                SEL_CLR:   r_d.mask  = r_q.mask & ~wdata_i;
                SEL_ROUTE: r_d.route = wdata_i;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_o  = r_q.mask;
    assign route_o = r_q.route;

endmodule

// File: rtl/irq_outgen.sv
module irq_outgen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] route_i,
    output logic [W-1:0] stat0_o,
    output logic [W-1:0] stat1_o,
    output logic [1:0]   irq_o
);

    localparam int GLB = W - 1;
    localparam logic [W-1:0] SRC_ONLY = ~(W'(1) << GLB);

    typedef struct packed {
        logic [1:0] line;
    } out_t;

    out_t o_d, o_q;
    logic [W-1:0] qual;
    logic         master;

    always_comb begin
        master  = mask_i[GLB];
        qual    = raw_i & mask_i & SRC_ONLY;
        stat0_o = qual & ~route_i;
        stat1_o = qual & route_i;
        o_d.line[0] = master & (|stat0_o);
        o_d.line[1] = master & (|stat1_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_o = o_q.line;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int W           = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [W-1:0]      reg_wdata_i,
    output logic [W-1:0]      reg_rdata_o,
    output logic [1:0]        irq_o
);

    reg_sel_e     sel;
    logic [W-1:0] raw_w;
    logic [W-1:0] mask_w;
    logic [W-1:0] route_w;
    logic [W-1:0] stat0_w;
    logic [W-1:0] stat1_w;

    always_comb begin
        if (reg_addr_i == ADDR_W'(OFS_LINE0))      sel = SEL_LINE0;
        else if (reg_addr_i == ADDR_W'(OFS_LINE1)) sel = SEL_LINE1;
        else if (reg_addr_i == ADDR_W'(OFS_ROUTE)) sel = SEL_ROUTE;
        else if (reg_addr_i == ADDR_W'(OFS_RAW))   sel = SEL_RAW;
        else if (reg_addr_i == ADDR_W'(OFS_SET))   sel = SEL_SET;
        else if (reg_addr_i == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
        else                                       sel = SEL_NONE;
    end

    irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (raw_w)
    );

    irq_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .sel_i   (sel),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_w),
        .route_o (route_w)
    );

    irq_outgen #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_w),
        .mask_i  (mask_w),
        .route_i (route_w),
        .stat0_o (stat0_w),
        .stat1_o (stat1_w),
        .irq_o   (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_LINE0:        reg_rdata_o = stat0_w;
            SEL_LINE1:        reg_rdata_o = stat1_w;
            SEL_ROUTE:        reg_rdata_o = route_w;
            SEL_RAW:          reg_rdata_o = raw_w;
            SEL_SET, SEL_CLR: reg_rdata_o = mask_w;
            default:          reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [W-1:0]      reg_wdata_i,
    input logic [W-1:0]      mask,
    input logic [W-1:0]      stat0,
    input logic [W-1:0]      stat1,
    input logic [1:0]        irq_o
);

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_W'(OFS_SET))
        |=> ((mask & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_W'(OFS_CLR))
        |=> ((mask & $past(reg_wdata_i)) == '0));

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we_i |=> $stable(mask));

    assert_master_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != 2'b00) |-> $past(mask[W-1]));

    assert_line_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0);

    assert_line0_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] |-> $past(|stat0));

    assert_line1_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] |-> $past(|stat1));

endmodule

bind irq_router irq_router_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .mask        (mask_w),
    .stat0       (stat0_w),
    .stat1       (stat1_w),
    .irq_o       (irq_o)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;

    localparam time PERIOD = 10ns;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    irq_router u_irq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // monitor: pops expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {30'b0, irq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        addr = a;
        q.push_back('{1'b0, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        q.push_back('{1'b1, {30'b0, e}, tag});
        @(negedge clk); #1;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(8'h34, 32'h0, "R1 mask");
        chk_rd(8'h20, 32'h0, "R1 route");
        chk_irq(2'b00, "R1 lines");

        // R2 set window, master off
        wr(8'h34, 32'h0000_00F0);
        chk_rd(8'h34, 32'h0000_00F0, "R2 set");
        src = 32'h0000_0010;
        idle(4);
        chk_rd(8'h30, 32'h0000_0010, "R6 raw");
        chk_rd(8'h00, 32'h0000_0010, "R7 line0 status");
        chk_irq(2'b00, "R4 master off");

        // R8 registered output after master enable
        wr(8'h34, 32'h8000_0000);
        chk_irq(2'b00, "R8 one edge later");
        idle(1);
        chk_irq(2'b01, "R8 line0 high");
        chk_rd(8'h34, 32'h8000_00F0, "R2 keep others");

        // R5 routing to line 1
        wr(8'h20, 32'h0000_0010);
        chk_rd(8'h20, 32'h0000_0010, "R5 route readback");
        idle(1);
        chk_irq(2'b10, "R5 line1");
        chk_rd(8'h04, 32'h0000_0010, "R7 line1 status");
        chk_rd(8'h00, 32'h0000_0000, "R7 line0 empty");

        // R9 level behaviour
        idle(5);
        chk_irq(2'b10, "R9 held");
        src = 32'h0;
        idle(2);
        chk_irq(2'b10, "R9 latency");
        idle(1);
        chk_irq(2'b00, "R9 dropped");

        // R10 ignored writes and unmapped reads
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        chk_rd(8'h34, 32'h8000_00F0, "R10 mask kept");
        chk_rd(8'h38, 32'h8000_00F0, "R3 clear reads mask");
        chk_rd(8'h20, 32'h0000_0010, "R10 route kept");
        chk_rd(8'h30, 32'h0000_0000, "R10 raw kept");
        chk_rd(8'h10, 32'h0000_0000, "R10 unmapped");

        // R3 clear window
        wr(8'h38, 32'h0000_0020);
        chk_rd(8'h34, 32'h8000_00D0, "R3 clear one");

        // R7 bit 31 never in status
        src = 32'h8000_0080;
        idle(4);
        chk_rd(8'h30, 32'h8000_0080, "R6 raw bit31");
        chk_rd(8'h00, 32'h0000_0080, "R7 bit31 masked");
        chk_irq(2'b01, "R8 line0");

        // R8 both lines, R4 master toggling
        src = 32'h8000_0090;
        idle(4);
        chk_irq(2'b11, "R8 both lines");
        wr(8'h38, 32'h8000_0000);
        idle(1);
        chk_irq(2'b00, "R4 master cleared");
        wr(8'h34, 32'h8000_0000);
        idle(1);
        chk_irq(2'b11, "R4 master restored");

        // collision: clear write lands with raw rising
        src = 32'h0;
        idle(4);
        chk_irq(2'b00, "R9 all low");
        src = 32'h0000_0040;
        wr(8'h38, 32'h0000_0040);
        chk_irq(2'b00, "R3 collision a");
        chk_irq(2'b00, "R3 collision b");
        chk_irq(2'b00, "R3 collision c");
        chk_rd(8'h30, 32'h0000_0040, "R6 raw in collision");
        chk_rd(8'h00, 32'h0000_0000, "R3 status after clear");

        // R3 clear everything
        wr(8'h38, 32'hFFFF_FFFF);
        chk_rd(8'h34, 32'h0000_0000, "R3 clear all");
        src = 32'hFFFF_FFFF;
        idle(4);
        chk_irq(2'b00, "R4 all disabled");

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule